// File: doc/BRIEF.md
# Memory Security Attribution Combiner

This block assigns a security attribute to every address the core presents: Secure, Non-secure, or Non-secure-callable (NSC). The answer comes from two sources. The first is a small programmable table of address regions, held in registers that are written through a simple write port. The second is a fixed attribution source that arrives on side-band inputs. That fixed source can exempt an address from attribution entirely. It can also raise the table's answer towards Secure, but it can never lower it.

The lookup is purely combinational from the address and side-band inputs to the outputs. Only the table and its two control bits are registered. Instruction fetches from the top 256 MB are always treated as Secure. An exempt address takes the inverse of the current security state. For every other address, the table result is formed first and the fixed source then overrides it where that source demands more security. The number of the matching table region and the fixed source's region number are reported together with valid flags. Parameter `FIX_PRESENT = 0` models a block with no fixed source connected; in that case its inputs are ignored and neutral defaults are used in their place.

Top module: `sec_attr_combiner`

## Requirements
- R1: An instruction fetch (`is_fetch`=1) whose address has 0xF in bits 31:28 gives `ns`=0 and `nsc`=0, with both region valid outputs low. This rule takes precedence over every other rule.
- R2: Otherwise, if `fix_exempt`=1, or the address lies in the built-in exempt range (0xE000_0000 to 0xE00F_FFFF inclusive), then `ns` = !`cur_secure`, `nsc`=0 and both region valid outputs are low.
- R3: Otherwise, `fix_region_out_ok` follows `fix_region_ok`, and `fix_region_out` equals `fix_region` when that source is valid. When no region is reported, `fix_region_out` reads 0.
- R4: Control register bit 0 is the table-enable bit and bit 1 is the all-non-secure bit. With the table disabled, the table result is Secure when bit 1 is 0 and Non-secure when bit 1 is 1, and `tbl_region_ok` is 0.
- R5: With the table enabled, an address is tested against regions that are enabled and whose base is at or below the address and whose limit is at or above it, comparing address bits 31:5. One hit gives Non-secure, or NSC (`ns`=0, `nsc`=1) when that region's NSC bit is set. No hit, or two or more hits, gives Secure. `ns` and `nsc` are never both 1.
- R6: When exactly one enabled region hits, `tbl_region` is that region's index and `tbl_region_ok`=1. Otherwise `tbl_region_ok`=0 and `tbl_region` reads 0.
- R7: When `fix_ns`=0 and either the table said Non-secure, or the table said NSC while `fix_nsc`=0, the outputs are forced to `ns`=0 and `nsc`=`fix_nsc`. Otherwise the table result passes through unchanged.
- R8: With `FIX_PRESENT`=0, the outputs equal those of a block whose fixed inputs are exempt=0, ns=1, nsc=1 and region not valid, whatever is driven on the fixed inputs.
- R9: Write select map. Select 0 sets the control bits from `wr_data[1:0]`. Select 2k+1 sets region k's base from `wr_data[31:5]`. Select 2k+2 sets region k's limit from `wr_data[31:5]`, its NSC bit from `wr_data[1]` and its enable bit from `wr_data[0]`. The written value takes effect from the clock edge that captures it. Writes to any other select change nothing.
- R10: Synchronous active-high reset clears the control bits and every region (all regions disabled), so that afterwards every non-exempt lookup gives Secure when the fixed source does not override it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SEL_W | Register select (see R9) |
| wr_data | input | 32 | Register write data |
| addr | input | 32 | Address being attributed |
| is_fetch | input | 1 | Access is an instruction fetch |
| cur_secure | input | 1 | Current security state of the requester |
| fix_exempt | input | 1 | Fixed source: address exempt |
| fix_ns | input | 1 | Fixed source: Non-secure |
| fix_nsc | input | 1 | Fixed source: Non-secure-callable |
| fix_region | input | FIX_RW | Fixed source region number |
| fix_region_ok | input | 1 | Fixed source region number is valid |
| ns | output | 1 | Final Non-secure flag |
| nsc | output | 1 | Final Non-secure-callable flag |
| tbl_region | output | IDX_W | Matching table region index |
| tbl_region_ok | output | 1 | Table region index valid |
| fix_region_out | output | FIX_RW | Reported fixed region number |
| fix_region_out_ok | output | 1 | Reported fixed region valid |

## Verification
The lookup path is combinational, so a wrong stored base, limit, enable or NSC bit shows up at `ns`, `nsc` and `tbl_region` on the first probe that touches the affected window. That probe can come as soon as one cycle after the write. A corrupted control bit changes the answer for every address outside the fetch and exempt rules at once. Faults in rule ordering show up only for the particular input combinations involved: a fetch to the top nibble that is also exempt, or a table hit that the fixed source overrides. The random stimulus therefore drives addresses and side-band flags densely inside a narrow window, where overlaps and multiple hits are frequent.

// File: rtl/sattr_pkg.sv
package sattr_pkg;

    localparam int ADDR_W = 32;
    localparam int GRAIN  = 5;
    localparam int BLK_W  = ADDR_W - GRAIN;

    typedef logic [BLK_W-1:0] blk_t;

    typedef struct packed {
        logic ns;
        logic nsc;
    } attr_t;

    typedef struct packed {
        logic en;
        logic nsc;
        blk_t base;
        blk_t limit;
    } region_t;

    typedef struct packed {
        logic allns;
        logic tbl_on;
    } ctrl_t;

    localparam attr_t ATTR_SEC = '{ns: 1'b0, nsc: 1'b0};
    localparam attr_t ATTR_NS  = '{ns: 1'b1, nsc: 1'b0};
    localparam attr_t ATTR_NSC = '{ns: 1'b0, nsc: 1'b1};

    function automatic blk_t blk_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:GRAIN];
    endfunction

    function automatic logic in_window(input blk_t b, input region_t r);
        return r.en && (b >= r.base) && (b <= r.limit);
    endfunction

endpackage

// File: rtl/sattr_region_file.sv
module sattr_region_file
    import sattr_pkg::*;
#(
    parameter int REGIONS = 8,
    parameter int SEL_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output ctrl_t             ctrl_o,
    output region_t           regs_o [REGIONS]
);

    ctrl_t ctrl_q;
    logic  unused_low_bits;

    assign unused_low_bits = ^wr_data[GRAIN-1:2];
    assign ctrl_o = ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en && wr_sel == '0) begin
            ctrl_q <= ctrl_t'(wr_data[1:0]);
        end
    end

    for (genvar g = 0; g < REGIONS; g++) begin : g_region
        localparam logic [SEL_W-1:0] SEL_BASE = SEL_W'(2 * g + 1);
        localparam logic [SEL_W-1:0] SEL_LIM  = SEL_W'(2 * g + 2);
        region_t r_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                r_q <= '0;
            end else if (wr_en) begin
                if (wr_sel == SEL_BASE) begin
                    r_q.base <= blk_of(wr_data);
                end
                if (wr_sel == SEL_LIM) begin
                    r_q.limit <= blk_of(wr_data);
                    r_q.nsc   <= wr_data[1];
                    r_q.en    <= wr_data[0];
                end
            end
        end

        assign regs_o[g] = r_q;
    end

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) == 1'b0 && $past(wr_en) && $past(wr_sel) == '0)
            |-> ctrl_o == ctrl_t'($past(wr_data[1:0]))) else $error("ctrl write"); // R9

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) == 1'b0 && !($past(wr_en) && $past(wr_sel) == '0))
            |-> $stable(ctrl_o)) else $error("ctrl hold"); // R9

endmodule

// File: rtl/sattr_region_match.sv
module sattr_region_match
    import sattr_pkg::*;
#(
    parameter int REGIONS = 8,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  blk_t             blk_i,
    input  region_t          regs_i [REGIONS],
    output logic             single_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             hit_nsc_o
);

    logic [REGIONS-1:0] hits;

    for (genvar g = 0; g < REGIONS; g++) begin : g_cmp
        assign hits[g] = in_window(blk_i, regs_i[g]);
    end

    always_comb begin
        idx_o = '0;
        for (int k = REGIONS - 1; k >= 0; k--) begin
            if (hits[k]) idx_o = IDX_W'(k);
        end
    end

    assign single_o  = ($countones(hits) == 1);
    assign hit_nsc_o = regs_i[idx_o].nsc;

    AST_SINGLE_POINTS_AT_HIT: assert property (@(posedge clk) disable iff (rst)
        single_o |-> hits[idx_o]) else $error("index not a hit"); // R6

    AST_SINGLE_IS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        single_o |-> $onehot0(hits) && hits != '0) else $error("single mismatch"); // R5

endmodule

// File: rtl/sattr_merge.sv
module sattr_merge
    import sattr_pkg::*;
#(
    parameter int                IDX_W     = 3,
    parameter int                FIX_RW    = 8,
    parameter logic [ADDR_W-1:0] EXEMPT_LO = 32'hE000_0000,
    parameter logic [ADDR_W-1:0] EXEMPT_HI = 32'hE00F_FFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              fetch_i,
    input  logic              cur_sec_i,
    input  ctrl_t             ctrl_i,
    input  logic              single_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              hit_nsc_i,
    input  logic              fx_exempt_i,
    input  attr_t             fx_attr_i,
    input  logic [FIX_RW-1:0] fx_region_i,
    input  logic              fx_region_ok_i,
    output attr_t             attr_o,
    output logic [IDX_W-1:0]  tbl_idx_o,
    output logic              tbl_ok_o,
    output logic [FIX_RW-1:0] fx_region_o,
    output logic              fx_ok_o
);

    logic  fetch_top;
    logic  exempt;
    attr_t tbl_attr;
    attr_t merged;

    assign fetch_top = fetch_i && (addr_i[ADDR_W-1:ADDR_W-4] == 4'hF);
    assign exempt    = fx_exempt_i || ((addr_i >= EXEMPT_LO) && (addr_i <= EXEMPT_HI));

    always_comb begin
        if (!ctrl_i.tbl_on) begin
            tbl_attr = ctrl_i.allns ? ATTR_NS : ATTR_SEC;
        end else if (single_i) begin
            tbl_attr = hit_nsc_i ? ATTR_NSC : ATTR_NS;
        end else begin
            tbl_attr = ATTR_SEC;
        end
    end

    always_comb begin
        merged = tbl_attr;
        if (!fx_attr_i.ns && (tbl_attr.ns || (!fx_attr_i.nsc && tbl_attr.nsc))) begin
            merged.ns  = 1'b0;
            merged.nsc = fx_attr_i.nsc;
        end
    end

    always_comb begin
        attr_o      = merged;
        tbl_ok_o    = ctrl_i.tbl_on && single_i;
        fx_ok_o     = fx_region_ok_i;
        if (fetch_top) begin
            attr_o   = ATTR_SEC;
            tbl_ok_o = 1'b0;
            fx_ok_o  = 1'b0;
        end else if (exempt) begin
            attr_o   = '{ns: !cur_sec_i, nsc: 1'b0};
            tbl_ok_o = 1'b0;
            fx_ok_o  = 1'b0;
        end
        tbl_idx_o   = tbl_ok_o ? idx_i : '0;
        fx_region_o = fx_ok_o ? fx_region_i : '0;
    end

    AST_FETCH_TOP_SECURE: assert property (@(posedge clk) disable iff (rst)
        fetch_top |-> (!attr_o.ns && !attr_o.nsc && !tbl_ok_o && !fx_ok_o)) else $error("fetch"); // R1

    AST_EXEMPT_FOLLOWS_STATE: assert property (@(posedge clk) disable iff (rst)
        (!fetch_top && fx_exempt_i) |-> (attr_o.ns == !cur_sec_i && !attr_o.nsc)) else $error("exempt"); // R2

    AST_FIX_SECURE_WINS: assert property (@(posedge clk) disable iff (rst)
        (!fetch_top && !exempt && !fx_attr_i.ns) |-> !attr_o.ns) else $error("override"); // R7

    AST_NS_NSC_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(attr_o.ns && attr_o.nsc)) else $error("ns and nsc"); // R5

    AST_DISABLED_NO_IDX: assert property (@(posedge clk) disable iff (rst)
        !ctrl_i.tbl_on |-> !tbl_ok_o) else $error("disabled idx"); // R4

endmodule

// File: rtl/sec_attr_combiner.sv
module sec_attr_combiner
    import sattr_pkg::*;
#(
    parameter int                REGIONS     = 8,
    parameter int                FIX_RW      = 8,
    parameter bit                FIX_PRESENT = 1'b1,
    parameter logic [31:0]       EXEMPT_LO   = 32'hE000_0000,
    parameter logic [31:0]       EXEMPT_HI   = 32'hE00F_FFFF,
    parameter int                IDX_W       = $clog2(REGIONS),
    parameter int                SEL_W       = $clog2(2 * REGIONS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [31:0]       wr_data,
    input  logic [31:0]       addr,
    input  logic              is_fetch,
    input  logic              cur_secure,
    input  logic              fix_exempt,
    input  logic              fix_ns,
    input  logic              fix_nsc,
    input  logic [FIX_RW-1:0] fix_region,
    input  logic              fix_region_ok,
    output logic              ns,
    output logic              nsc,
    output logic [IDX_W-1:0]  tbl_region,
    output logic              tbl_region_ok,
    output logic [FIX_RW-1:0] fix_region_out,
    output logic              fix_region_out_ok
);

    ctrl_t             ctrl;
    region_t           regs [REGIONS];
    logic              single;
    logic [IDX_W-1:0]  idx;
    logic              hit_nsc;
    logic              fx_exempt;
    attr_t             fx_attr;
    logic [FIX_RW-1:0] fx_region;
    logic              fx_region_ok;
    attr_t             attr;

    generate
        if (FIX_PRESENT) begin : g_fix
            assign fx_exempt    = fix_exempt;
            assign fx_attr      = '{ns: fix_ns, nsc: fix_nsc};
            assign fx_region    = fix_region;
            assign fx_region_ok = fix_region_ok;
        end else begin : g_nofix
            logic unused_fix;
            assign unused_fix   = fix_exempt ^ fix_ns ^ fix_nsc ^ (^fix_region) ^ fix_region_ok;
            assign fx_exempt    = 1'b0;
            assign fx_attr      = '{ns: 1'b1, nsc: 1'b1};
            assign fx_region    = '0;
            assign fx_region_ok = 1'b0;
        end
    endgenerate

    sattr_region_file #(.REGIONS(REGIONS), .SEL_W(SEL_W)) u_file (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ctrl_o  (ctrl),
        .regs_o  (regs)
    );

    sattr_region_match #(.REGIONS(REGIONS), .IDX_W(IDX_W)) u_match (
        .clk       (clk),
        .rst       (rst),
        .blk_i     (blk_of(addr)),
        .regs_i    (regs),
        .single_o  (single),
        .idx_o     (idx),
        .hit_nsc_o (hit_nsc)
    );

    sattr_merge #(
        .IDX_W(IDX_W), .FIX_RW(FIX_RW), .EXEMPT_LO(EXEMPT_LO), .EXEMPT_HI(EXEMPT_HI)
    ) u_merge (
        .clk            (clk),
        .rst            (rst),
        .addr_i         (addr),
        .fetch_i        (is_fetch),
        .cur_sec_i      (cur_secure),
        .ctrl_i         (ctrl),
        .single_i       (single),
        .idx_i          (idx),
        .hit_nsc_i      (hit_nsc),
        .fx_exempt_i    (fx_exempt),
        .fx_attr_i      (fx_attr),
        .fx_region_i    (fx_region),
        .fx_region_ok_i (fx_region_ok),
        .attr_o         (attr),
        .tbl_idx_o      (tbl_region),
        .tbl_ok_o       (tbl_region_ok),
        .fx_region_o    (fix_region_out),
        .fx_ok_o        (fix_region_out_ok)
    );

    assign ns  = attr.ns;
    assign nsc = attr.nsc;

endmodule

// File: tb/test_sec_attr_combiner.sv
module test_sec_attr_combiner;

    localparam int NREG = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] addr = '0;
    logic        is_fetch = 1'b0, cur_secure = 1'b0;
    logic        fix_exempt = 1'b0, fix_ns = 1'b1, fix_nsc = 1'b1, fix_region_ok = 1'b0;
    logic [7:0]  fix_region = '0;

    logic ns_a, nsc_a, tok_a, fok_a, ns_b, nsc_b, tok_b, fok_b;
    logic [2:0] tidx_a, tidx_b;
    logic [7:0] fidx_a, fidx_b;

    int checks = 0;
    int failures = 0;

    logic [26:0] m_base [NREG];
    logic [26:0] m_lim  [NREG];
    logic        m_en   [NREG];
    logic        m_nsc  [NREG];
    logic [1:0]  m_ctrl;

    always #5 clk = ~clk;

    sec_attr_combiner i_sec_attr_combiner (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .addr(addr), .is_fetch(is_fetch), .cur_secure(cur_secure),
        .fix_exempt(fix_exempt), .fix_ns(fix_ns), .fix_nsc(fix_nsc),
        .fix_region(fix_region), .fix_region_ok(fix_region_ok),
        .ns(ns_a), .nsc(nsc_a), .tbl_region(tidx_a), .tbl_region_ok(tok_a),
        .fix_region_out(fidx_a), .fix_region_out_ok(fok_a));

    sec_attr_combiner #(.FIX_PRESENT(1'b0)) i_sec_attr_combiner_nofix (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .addr(addr), .is_fetch(is_fetch), .cur_secure(cur_secure),
        .fix_exempt(fix_exempt), .fix_ns(fix_ns), .fix_nsc(fix_nsc),
        .fix_region(fix_region), .fix_region_ok(fix_region_ok),
        .ns(ns_b), .nsc(nsc_b), .tbl_region(tidx_b), .tbl_region_ok(tok_b),
        .fix_region_out(fidx_b), .fix_region_out_ok(fok_b));

    // Expected {ns, nsc, tbl_ok, tbl_idx[2:0], fix_ok, fix_idx[7:0]}
    function automatic logic [14:0] model(input logic fe, input logic fn, input logic fc,
                                          input logic [7:0] fr, input logic fok);
        logic t_ns, t_nsc, t_ok, f_ns, f_nsc;
        logic [2:0] t_idx;
        int nhit;
        if (is_fetch && addr[31:28] == 4'hF) return '0;                          // R1
        if (fe || (addr >= 32'hE000_0000 && addr <= 32'hE00F_FFFF))              // R2
            return {!cur_secure, 14'd0};
        nhit = 0; t_idx = '0;
        for (int k = NREG - 1; k >= 0; k--) begin
            if (m_en[k] && addr[31:5] >= m_base[k] && addr[31:5] <= m_lim[k]) begin
                nhit++; t_idx = 3'(k);
            end
        end
        t_ok = 1'b0; t_nsc = 1'b0;
        if (!m_ctrl[0]) t_ns = m_ctrl[1];                                        // R4
        else if (nhit == 1) begin                                                // R5 R6
            t_ns = !m_nsc[t_idx]; t_nsc = m_nsc[t_idx]; t_ok = 1'b1;
        end else t_ns = 1'b0;
        f_ns = t_ns; f_nsc = t_nsc;
        if (!fn && (t_ns || (!fc && t_nsc))) begin f_ns = 1'b0; f_nsc = fc; end  // R7
        return {f_ns, f_nsc, t_ok, t_ok ? t_idx : 3'd0, fok, fok ? fr : 8'd0};   // R3
    endfunction

    task automatic wr(input int sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 5'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel == 0) m_ctrl = d[1:0];
        else if (sel <= 2 * NREG) begin
            if (sel % 2 == 1) m_base[(sel - 1) / 2] = d[31:5];
            else begin
                m_lim[(sel - 1) / 2] = d[31:5];
                m_nsc[(sel - 1) / 2] = d[1];
                m_en[(sel - 1) / 2]  = d[0];
            end
        end
    endtask

    task automatic probe(input string tag, input logic [31:0] a, input logic f, input logic s,
                         input logic fe, input logic fn, input logic fc,
                         input logic [7:0] fr, input logic fok);
        logic [14:0] exp_a, exp_b, got_a, got_b;
        addr = a; is_fetch = f; cur_secure = s;
        fix_exempt = fe; fix_ns = fn; fix_nsc = fc; fix_region = fr; fix_region_ok = fok;
        #2;
        exp_a = model(fe, fn, fc, fr, fok);
        exp_b = model(1'b0, 1'b1, 1'b1, 8'd0, 1'b0);
        got_a = {ns_a, nsc_a, tok_a, tidx_a, fok_a, fidx_a};
        got_b = {ns_b, nsc_b, tok_b, tidx_b, fok_b, fidx_b};
        checks++;
        if (got_a !== exp_a) begin
            failures++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, got_a, exp_a);
        end
        checks++;
        if (got_b !== exp_b) begin
            failures++;
            $display("FAIL R8 (%s, no fixed source) addr=%h actual=%h expected=%h", tag, a, got_b, exp_b);
        end
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] seed_sink;
        seed_sink = $urandom(32'd1357);
        m_ctrl = '0;
        for (int k = 0; k < NREG; k++) begin
            m_base[k] = '0; m_lim[k] = '0; m_en[k] = 1'b0; m_nsc[k] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: after reset, table off and all-non-secure off -> Secure
        probe("R10 reset", 32'h0000_0040, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd0, 1'b0);

        // R4: all-non-secure with table disabled
        wr(0, 32'h2);
        probe("R4 allns", 32'h0000_0100, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd0, 1'b0);
        // R3: fixed region reported
        probe("R3 fix region", 32'h0000_0100, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h5A, 1'b1);
        // R1: fetch from top nibble is Secure even though table says NS
        probe("R1 fetch top", 32'hF000_1234, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h11, 1'b1);
        probe("R1 data top", 32'hF000_1234, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h11, 1'b1);
        // R2: side-band exempt and built-in range
        probe("R2 fix exempt", 32'h0000_0100, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3, 1'b1);
        probe("R2 builtin lo", 32'hE000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h0, 1'b0);
        probe("R2 builtin hi", 32'hE00F_FFFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h0, 1'b0);
        probe("R2 past range", 32'hE010_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h0, 1'b0);
        // R7: fixed source forces Secure over table NS
        probe("R7 force sec", 32'h0000_0100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0, 1'b0);
        probe("R7 force nsc", 32'h0000_0100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0, 1'b0);

        // R9: region 2 with junk in low bits, enabled, NSC
        wr(5, 32'h0000_101F);
        wr(6, 32'h0000_11FF);
        wr(0, 32'h1);
        probe("R9 base lowbits", 32'h0000_1000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h0, 1'b0);
        probe("R5 nsc hit", 32'h0000_11FF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h0, 1'b0);
        probe("R5 miss", 32'h0000_1200, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h0, 1'b0);
        // R7: table NSC, fixed says Secure non-NSC -> Secure
        probe("R7 nsc to sec", 32'h0000_1100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0, 1'b0);
        probe("R7 nsc kept", 32'h0000_1100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0, 1'b0);
        // R6: overlapping region 5 -> multiple hits -> Secure, no index
        wr(11, 32'h0000_1100);
        wr(12, 32'h0000_1300 | 32'h1);
        probe("R6 multi hit", 32'h0000_1180, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h0, 1'b0);
        probe("R6 single r5", 32'h0000_1280, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h0, 1'b0);
        // R9: unused select ignored
        wr(31, 32'hFFFF_FFFF);
        wr(17, 32'hFFFF_FFFF);
        probe("R9 unused sel", 32'h0000_1280, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h0, 1'b0);

        // Random phase
        for (int it = 0; it < 3000; it++) begin
            logic [31:0] a;
            if (it % 60 == 0) begin
                for (int k = 0; k < NREG; k++) begin
                    logic [31:0] b;
                    b = ($urandom % 256) << 5;
                    wr(2 * k + 1, b | ($urandom % 32));
                    wr(2 * k + 2, (b + (($urandom % 40) << 5)) | ($urandom % 4));
                end
                wr(0, $urandom % 4);
            end
            case ($urandom % 10)
                0:       a = 32'hF000_0000 | ($urandom % 32'h0FFF_FFFF);
                1:       a = 32'hE000_0000 | ($urandom % 32'h0020_0000);
                default: a = $urandom % 32'h0000_2200;
            endcase
            probe("R5 random", a, 1'($urandom), 1'($urandom), ($urandom % 8) == 0,
                  1'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
        end

        // R10: reset clears the table again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_ctrl = '0;
        for (int k = 0; k < NREG; k++) begin
            m_base[k] = '0; m_lim[k] = '0; m_en[k] = 1'b0; m_nsc[k] = 1'b0;
        end
        probe("R10 re-reset", 32'h0000_0100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule